// File: doc/BRIEF.md
# Fault address capture register

This block holds the virtual address that caused a synchronous exception taken to the first privileged exception level. Whenever the exception logic signals that such an exception is being taken, the block inspects the 6-bit exception class. It stores the faulting address only for instruction aborts, PC alignment faults, data aborts and watchpoints. Before storing, it reshapes the address according to the fault qualifiers. An address from 32-bit state loses its upper half. An external abort whose address is flagged not valid is stored as zero and marked invalid. An external abort that had top-byte-ignore active has its top byte cleared. A partial data access or watchpoint stores the address aligned down to the fault granule.

Privileged software may also write the register directly through a plain write strobe. The full 64-bit value can always be read. Two 32-bit views expose the low half as a data-fault address and the high half as an instruction-fault address. Every input is a single-cycle strobe or a level sampled with it. There is no back-pressure: the block accepts a capture or a write on every clock, and the result is visible from the next cycle.

Top module: `fault_addr_capture`

## Requirements
- R1: After reset, `far_q` is zero and `addr_invalid` is 0.
- R2: When `exc_take` and `exc_to_lvl1` are both 1 and `exc_class` is one of 0x20, 0x21, 0x22, 0x24, 0x25, 0x34 or 0x35, the shaped address appears on `far_q` one cycle later.
- R3: When `exc_take` is 0, or `exc_to_lvl1` is 0, or the class is outside that set, a capture leaves `far_q` and `addr_invalid` unchanged.
- R4: A capture with `exc_from_32` set stores bits 63:32 as zero.
- R5: A capture with `ext_abort`=1, `ext_on_walk`=0 and `addr_not_valid`=1 stores zero and sets `addr_invalid`. `addr_not_valid` is ignored when `ext_on_walk` is 1 or `ext_abort` is 0. Any other capture, and any software write, clears `addr_invalid`.
- R6: A capture with `ext_abort`=1 and `tbi_active`=1 stores bits 63:56 as zero. `tbi_active` has no effect without `ext_abort`.
- R7: A capture with `access_partial`=1 and class 0x24, 0x25, 0x34 or 0x35 stores the address with its low GRAN_LG2 bits cleared. GRAN_LG2 defaults to 4, a 16-byte granule. `access_partial` is ignored for the other classes.
- R8: `dfar_view` always equals `far_q[31:0]`, and `ifar_view` always equals `far_q[63:32]`.
- R9: `sw_wr_en` loads `sw_wr_data` into `far_q` on the next edge. When a qualifying capture happens in the same cycle, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_take | input | 1 | Synchronous exception taken this cycle |
| exc_to_lvl1 | input | 1 | Exception targets the first privileged level |
| exc_class | input | 6 | Exception class code |
| exc_addr | input | 64 | Faulting virtual address |
| exc_from_32 | input | 1 | Exception came from 32-bit state |
| ext_abort | input | 1 | Fault is a synchronous external abort |
| ext_on_walk | input | 1 | External abort occurred on a table walk |
| addr_not_valid | input | 1 | Address-not-valid qualifier for the external abort |
| tbi_active | input | 1 | Top-byte-ignore applied to the address range |
| access_partial | input | 1 | Partial-access qualifier: the address may be reported at granule precision |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 64 | Software write value |
| far_q | output | 64 | Stored fault address |
| dfar_view | output | 32 | Low-half alias |
| ifar_view | output | 32 | High-half alias |
| addr_invalid | output | 1 | Stored address was reported as not valid |

## Verification
The hardest case to reach is a capture in which several shaping rules act at once. An example is an external abort with top-byte-ignore, taken from 32-bit state with a partial access on a watchpoint class, while software writes in the same cycle. The order of the masks and the capture priority matter only in that case. Directed steps set up each combination by hand. A long run of random cycles then draws every qualifier independently and biases the class toward the capturing codes, so that stacked cases occur often. A behavioural model in the bench is compared with the outputs on every cycle.

// File: rtl/fac_pkg.sv
package fac_pkg;
  localparam int EC_W = 6;

  localparam logic [EC_W-1:0] EC_IABT_LO  = 6'h20;
  localparam logic [EC_W-1:0] EC_IABT_CUR = 6'h21;
  localparam logic [EC_W-1:0] EC_PC_ALIGN = 6'h22;
  localparam logic [EC_W-1:0] EC_DABT_LO  = 6'h24;
  localparam logic [EC_W-1:0] EC_DABT_CUR = 6'h25;
  localparam logic [EC_W-1:0] EC_WP_LO    = 6'h34;
  localparam logic [EC_W-1:0] EC_WP_CUR   = 6'h35;

  function automatic logic ec_records_addr(input logic [EC_W-1:0] ec);
    return (ec == EC_IABT_LO) || (ec == EC_IABT_CUR) || (ec == EC_PC_ALIGN) ||
           (ec == EC_DABT_LO) || (ec == EC_DABT_CUR) ||
           (ec == EC_WP_LO)   || (ec == EC_WP_CUR);
  endfunction

  function automatic logic ec_is_data_side(input logic [EC_W-1:0] ec);
    return (ec == EC_DABT_LO) || (ec == EC_DABT_CUR) ||
           (ec == EC_WP_LO)   || (ec == EC_WP_CUR);
  endfunction
endpackage

// File: rtl/fac_qualify.sv
module fac_qualify
  import fac_pkg::*;
(
  input  logic            take,
  input  logic            to_lvl1,
  input  logic [EC_W-1:0] ec,
  input  logic            ext_abort,
  input  logic            on_walk,
  input  logic            not_valid,
  input  logic            tbi,
  input  logic            partial,
  output logic            capture,
  output logic            drop_addr,
  output logic            clr_top,
  output logic            do_align
);
  always_comb begin
    capture   = take & to_lvl1 & ec_records_addr(ec);
    drop_addr = ext_abort & ~on_walk & not_valid;
    clr_top   = ext_abort & tbi;
    do_align  = partial & ec_is_data_side(ec);
  end
endmodule

// File: rtl/fac_shaper.sv
module fac_shaper #(
  parameter int ADDR_W   = 64,
  parameter int GRAN_LG2 = 4
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              drop_addr,
  input  logic              clr_top,
  input  logic              do_align,
  input  logic              from_32,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int HALF_W  = ADDR_W / 2;
  localparam int TOP_LSB = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << GRAN_LG2) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] TOP_MASK   = {8'h00, {TOP_LSB{1'b1}}};
  localparam logic [ADDR_W-1:0] LOW_MASK   = {{(ADDR_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [ADDR_W-1:0] s0, s1, s2;

  always_comb begin
    s0       = drop_addr ? '0 : addr_in;
    s1       = clr_top   ? (s0 & TOP_MASK)   : s0;
    s2       = do_align  ? (s1 & ALIGN_MASK) : s1;
    addr_out = from_32   ? (s2 & LOW_MASK)   : s2;
  end
endmodule

// File: rtl/fac_store.sv
module fac_store #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] cap_val,
  input  logic              cap_invalid,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_val,
  output logic [ADDR_W-1:0] q,
  output logic              invalid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q         <= '0;
      invalid_q <= 1'b0;
    end else if (capture) begin
      q         <= cap_val;
      invalid_q <= cap_invalid;
    end else if (wr_en) begin
      q         <= wr_val;
      invalid_q <= 1'b0;
    end
  end

  a_r5_invalid_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_q |-> (q == '0));
endmodule

// File: rtl/fault_addr_capture.sv
module fault_addr_capture #(
  parameter int ADDR_W   = 64,
  parameter int GRAN_LG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_take,
  input  logic              exc_to_lvl1,
  input  logic [5:0]        exc_class,
  input  logic [ADDR_W-1:0] exc_addr,
  input  logic              exc_from_32,
  input  logic              ext_abort,
  input  logic              ext_on_walk,
  input  logic              addr_not_valid,
  input  logic              tbi_active,
  input  logic              access_partial,
  input  logic              sw_wr_en,
  input  logic [ADDR_W-1:0] sw_wr_data,
  output logic [ADDR_W-1:0] far_q,
  output logic [ADDR_W/2-1:0] dfar_view,
  output logic [ADDR_W/2-1:0] ifar_view,
  output logic              addr_invalid
);
  localparam int HALF_W  = ADDR_W / 2;
  localparam int TOP_LSB = ADDR_W - 8;

  logic capture, drop_addr, clr_top, do_align;
  logic [ADDR_W-1:0] shaped;

  fac_qualify u_qual (
    .take(exc_take), .to_lvl1(exc_to_lvl1), .ec(exc_class),
    .ext_abort(ext_abort), .on_walk(ext_on_walk), .not_valid(addr_not_valid),
    .tbi(tbi_active), .partial(access_partial),
    .capture(capture), .drop_addr(drop_addr), .clr_top(clr_top), .do_align(do_align)
  );

  fac_shaper #(.ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) u_shape (
    .addr_in(exc_addr), .drop_addr(drop_addr), .clr_top(clr_top),
    .do_align(do_align), .from_32(exc_from_32), .addr_out(shaped)
  );

  fac_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .capture(capture), .cap_val(shaped),
    .cap_invalid(drop_addr), .wr_en(sw_wr_en), .wr_val(sw_wr_data),
    .q(far_q), .invalid_q(addr_invalid)
  );

  assign dfar_view = far_q[HALF_W-1:0];
  assign ifar_view = far_q[ADDR_W-1:HALF_W];

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !sw_wr_en) |=> ($stable(far_q) && $stable(addr_invalid)));
  a_r4_upper_zero_from_32: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && exc_from_32) |=> (far_q[ADDR_W-1:HALF_W] == '0));
  a_r6_top_byte_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && ext_abort && tbi_active) |=> (far_q[ADDR_W-1:TOP_LSB] == '0));
  a_r7_granule_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && do_align) |=> (far_q[GRAN_LG2-1:0] == '0));
  a_r9_sw_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && !capture) |=> (far_q == $past(sw_wr_data) && !addr_invalid));
  a_r5_flag_on_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && drop_addr) |=> addr_invalid);
endmodule

// File: tb/tb_fault_addr_capture.sv
module tb_fault_addr_capture;
  localparam int G = 4;

  logic clk = 0, rst_n = 0;
  logic exc_take = 0, exc_to_lvl1 = 0, exc_from_32 = 0, ext_abort = 0, ext_on_walk = 0;
  logic addr_not_valid = 0, tbi_active = 0, access_partial = 0, sw_wr_en = 0;
  logic [5:0]  exc_class = 0;
  logic [63:0] exc_addr = 0, sw_wr_data = 0;
  logic [63:0] far_q;
  logic [31:0] dfar_view, ifar_view;
  logic        addr_invalid;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [63:0] m_far = 0;
  logic        m_inv = 0;

  always #10 clk = ~clk;

  fault_addr_capture #(.ADDR_W(64), .GRAN_LG2(G)) dut (.*);

  function automatic bit in_set(input logic [5:0] c);
    case (c)
      6'h20, 6'h21, 6'h22, 6'h24, 6'h25, 6'h34, 6'h35: return 1;
      default: return 0;
    endcase
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_far <= 0; m_inv <= 0; end
    else if (exc_take && exc_to_lvl1 && in_set(exc_class)) begin
      logic [63:0] a;
      bit bad;
      bad = ext_abort && !ext_on_walk && addr_not_valid;
      a = bad ? 64'h0 : exc_addr;
      if (ext_abort && tbi_active) a[63:56] = 8'h00;
      if (access_partial && (exc_class == 6'h24 || exc_class == 6'h25 ||
                             exc_class == 6'h34 || exc_class == 6'h35))
        a = (a >> G) << G;
      if (exc_from_32) a = {32'h0, a[31:0]};
      m_far <= a; m_inv <= bad;
    end else if (sw_wr_en) begin
      m_far <= sw_wr_data; m_inv <= 0;
    end
  end

  always @(negedge clk) if (!done) begin
    checks++;
    if (far_q !== m_far || addr_invalid !== m_inv) begin
      fails++;
      $display("FAIL %s: far_q=%h inv=%b expected far_q=%h inv=%b",
               cur_req, far_q, addr_invalid, m_far, m_inv);
    end
    checks++;
    if (dfar_view !== m_far[31:0] || ifar_view !== m_far[63:32]) begin
      fails++;  // R8 alias views
      $display("FAIL R8: dfar=%h ifar=%h expected dfar=%h ifar=%h",
               dfar_view, ifar_view, m_far[31:0], m_far[63:32]);
    end
  end

  task automatic exc(input string req, input logic [5:0] ec, input logic [63:0] a,
                     input bit lvl1, input bit f32, input bit ext, input bit walk,
                     input bit nv, input bit tbi, input bit part);
    cur_req = req;
    exc_take = 1; exc_to_lvl1 = lvl1; exc_class = ec; exc_addr = a;
    exc_from_32 = f32; ext_abort = ext; ext_on_walk = walk; addr_not_valid = nv;
    tbi_active = tbi; access_partial = part;
    @(negedge clk);
    exc_take = 0;
  endtask

  task automatic swr(input string req, input logic [63:0] d);
    cur_req = req; sw_wr_en = 1; sw_wr_data = d;
    @(negedge clk);
    sw_wr_en = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      done = 1;
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2: each capturing class
    exc("R2", 6'h20, 64'h1111_2222_3333_4440, 1, 0, 0, 0, 0, 0, 0);
    exc("R2", 6'h21, 64'hFEDC_BA98_7654_3210, 1, 0, 0, 0, 0, 0, 0);
    exc("R2", 6'h22, 64'h0000_0000_0000_0003, 1, 0, 0, 0, 0, 0, 0);
    exc("R2", 6'h24, 64'hAAAA_5555_AAAA_5555, 1, 0, 0, 0, 0, 0, 0);
    exc("R2", 6'h25, 64'h0123_4567_89AB_CDEF, 1, 0, 0, 0, 0, 0, 0);
    exc("R2", 6'h34, 64'h8000_0000_0000_0001, 1, 0, 0, 0, 0, 0, 0);
    exc("R2", 6'h35, 64'h7FFF_FFFF_FFFF_FFFE, 1, 0, 0, 0, 0, 0, 0);
    // R3: ignored classes, wrong target
    exc("R3", 6'h00, 64'hDEAD_BEEF_DEAD_BEEF, 1, 0, 0, 0, 0, 0, 0);
    exc("R3", 6'h15, 64'hDEAD_BEEF_DEAD_BEEF, 1, 0, 0, 0, 0, 0, 0);
    exc("R3", 6'h23, 64'hDEAD_BEEF_DEAD_BEEF, 1, 0, 0, 0, 0, 0, 0);
    exc("R3", 6'h24, 64'hDEAD_BEEF_DEAD_BEEF, 0, 0, 0, 0, 0, 0, 0);
    // R4
    exc("R4", 6'h24, 64'hFFFF_FFFF_1234_5678, 1, 1, 0, 0, 0, 0, 0);
    // R5
    exc("R5", 6'h25, 64'h1234_5678_9ABC_DEF0, 1, 0, 1, 0, 1, 0, 0);
    exc("R5", 6'h24, 64'h1234_5678_9ABC_DEF0, 1, 0, 1, 1, 1, 0, 0);
    exc("R5", 6'h25, 64'h1, 1, 0, 1, 0, 1, 0, 0);
    swr("R5", 64'h5A5A_5A5A_5A5A_5A5A);
    exc("R5", 6'h21, 64'hCAFE_0000_0000_0001, 1, 0, 0, 0, 1, 0, 0);
    // R6
    exc("R6", 6'h24, 64'hFF00_1234_5678_9ABC, 1, 0, 1, 1, 0, 1, 0);
    exc("R6", 6'h24, 64'hFF00_1234_5678_9ABC, 1, 0, 0, 0, 0, 1, 0);
    // R7
    exc("R7", 6'h25, 64'h0000_1234_5678_9ABF, 1, 0, 0, 0, 0, 0, 1);
    exc("R7", 6'h35, 64'h0000_1234_5678_9AB7, 1, 0, 0, 0, 0, 0, 1);
    exc("R7", 6'h20, 64'h0000_1234_5678_9ABF, 1, 0, 0, 0, 0, 0, 1);
    // R9
    swr("R9", 64'h0F0F_0F0F_0F0F_0F0F);
    cur_req = "R9"; sw_wr_en = 1; sw_wr_data = 64'h1111_1111_1111_1111;
    exc("R9", 6'h22, 64'h2222_2222_2222_2222, 1, 0, 0, 0, 0, 0, 0);
    sw_wr_en = 0;
    // stacked rules
    exc("R6", 6'h34, 64'hF0F0_F0F0_F0F0_F0FF, 1, 1, 1, 1, 0, 1, 1);
    @(negedge clk);
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] ec;
      ec = ($urandom_range(0, 3) != 0) ? 6'(6'h20 + $urandom_range(0, 21)) : 6'($urandom);
      sw_wr_en = $urandom_range(0, 3) == 0;
      sw_wr_data = {$urandom, $urandom};
      exc_take = $urandom_range(0, 1);
      exc_to_lvl1 = $urandom_range(0, 4) != 0;
      exc_class = ec; exc_addr = {$urandom, $urandom};
      exc_from_32 = $urandom_range(0, 3) == 0; ext_abort = $urandom_range(0, 1);
      ext_on_walk = $urandom_range(0, 1); addr_not_valid = $urandom_range(0, 1);
      tbi_active = $urandom_range(0, 1); access_partial = $urandom_range(0, 1);
      cur_req = "R2";
      @(negedge clk);
    end
    exc_take = 0; sw_wr_en = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule